// File: doc/BRIEF.md
# Video-Priority DRAM Arbiter and Controller

This block shares one DRAM between a CPU and a display fetch engine. It runs on a clock at twice the CPU rate, so each half CPU cycle is one tick. A raster timer supplies three inputs: the tick position inside a 24-tick display chunk, the chunk number inside the line, and whether the current line shows pixels. The block decodes the CPU's two high address bits into ROM, I/O and two RAM banks. It produces the DRAM strobes, the row/column mux select, the bus-transceiver enable and the CPU data acknowledge.

The display fetch always wins. In fetch chunks, the first 16 ticks belong to the video engine. During those ticks it runs a four-beat page-mode read on bank 0 on pixel lines, and a CAS-less refresh cycle on blank lines. The CPU gets one fixed 8-tick access at the end of each fetch chunk. In retrace chunks the CPU may start on any rising CPU edge, provided its access ends before the next fetch slot. An I/O access runs as a RAM-style cycle without CAS. In that cycle the block raises either a peripheral enable or a one-tick control-register write strobe, chosen by address bit 6. That bit is read from multiplexed DRAM address line 3 during the column phase.

Top module: `vpa_dram_ctrl`

## Requirements
- R1: `addr_hi` 2'b00 selects ROM and 2'b01 selects I/O. 2'b1x selects RAM, and `addr_hi[0]` picks the bank, so that only `cas_n[addr_hi[0]]` strobes.
- R2: `rom_oe` is high exactly when `ds_n` is low, `rw` is high and `addr_hi` is 2'b00. `dtack_n` is low in that same tick, with no stall.
- R3: In chunks 0 to 31, `vid_grant` is high at ticks 0 to 15, and `ras_n` is low at ticks 1 to 14. `vid_grant` is low at all other times.
- R4: During the video slot on a pixel line, `cas_n[0]` is low at ticks 3, 4, 6, 7, 9, 10, 12 and 13. On a blank line no CAS falls in the slot. `we_n` stays high throughout the slot.
- R5: In chunks 0 to 31, a CPU RAM/I/O access may begin only at tick 16. A request made earlier is held until then.
- R6: In chunks 32 to 39, an access may begin at any even tick whose 8 ticks fit before the next fetch slot. Chunk 39 allows starts only up to tick 16. A request that does not fit is held. An access may run across a boundary into a following retrace chunk.
- R7: An access occupies offsets 0 to 7 from its start tick. Offset 0 is the start tick. `mux_col` is low at offsets 0 and 1 and high at offsets 2 to 7. `ras_n` is low at offsets 1 to 6, and the bank's CAS is low at offsets 3 to 6.
- R8: On a CPU write (`rw` low), `we_n` is low at offsets 2 to 6. It is high on reads.
- R9: An I/O access drives no CAS. Address bit 6 is sampled from `dram_a3` at offset 2. If that bit is 0, `pcen_n` is low at offsets 3 to 6. If it is 1 and the access is a write, `ctrl_wr` is high at offset 3 only.
- R10: `xcvr_en_n` is low exactly when `vid_grant` is low and `ras_n` is low.
- R11: For RAM/I/O, `dtack_n` goes low at offset 3 and stays low until the tick after `ds_n` returns high. Only one access runs per strobe. Out of reset, all strobes are inactive.

Ports are listed below. Tick numbers refer to `slot_pos`, and an even tick is a rising CPU edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock |
| rst_n | input | 1 | Active-low reset |
| slot_pos | input | 5 | Tick inside the chunk, 0 to 23 |
| chunk_idx | input | 6 | Chunk inside the line, 0 to 39 |
| line_active | input | 1 | Current line displays pixels |
| ds_n | input | 1 | CPU data strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| addr_hi | input | 2 | CPU address bits 17:16 |
| dram_a3 | input | 1 | Multiplexed DRAM address line 3 |
| rom_oe | output | 1 | ROM output enable |
| vid_grant | output | 1 | Video engine owns memory |
| ras_n | output | 1 | Row strobe |
| cas_n | output | 2 | Column strobes, one per bank |
| we_n | output | 1 | DRAM write enable |
| mux_col | output | 1 | 1 = column address on mux |
| xcvr_en_n | output | 1 | CPU-to-memory transceiver enable |
| dtack_n | output | 1 | CPU data acknowledge |
| pcen_n | output | 1 | Peripheral chip enable |
| ctrl_wr | output | 1 | Internal control register write strobe |

## Verification
Requests are placed at chosen chunk and tick positions, and each placement answers a specific question. An early request inside a fetch chunk shows whether the grant waits for tick 16. An odd tick in retrace shows whether the start moves to the next CPU edge. Tick 18 of chunk 39 shows whether a request that would collide with the next line's fetch is held. Tick 16 of chunk 39 is the last start that still fits. Repeating the fetch-chunk request on a blank line separates refresh from page-mode reads. Running I/O with both values of bit 6, for both read and write, separates the peripheral enable from the control write. Keeping the strobe low after the acknowledge shows that no second access starts.

// File: rtl/vpa_pkg.sv
package vpa_pkg;
   typedef enum logic [1:0] {
      RGN_ROM  = 2'b00,
      RGN_IO   = 2'b01,
      RGN_RAM0 = 2'b10,
      RGN_RAM1 = 2'b11
   } region_e;

   localparam int TICKS_PER_CHUNK = 24;
   localparam int VIDEO_TICKS     = 16;
   localparam int ACCESS_TICKS    = 8;
endpackage

// File: rtl/vpa_decode.sv
module vpa_decode
   import vpa_pkg::*;
(
   input  logic       ds_n,
   input  logic       rw,
   input  logic [1:0] addr_hi,
   output logic       rom_oe,
   output logic       mem_req,
   output logic       is_io,
   output logic       bank,
   output logic       is_wr
);
   region_e rgn;
   assign rgn     = region_e'(addr_hi);
   assign rom_oe  = !ds_n && rw && (rgn == RGN_ROM);
   assign mem_req = !ds_n && (rgn != RGN_ROM);
   assign is_io   = (rgn == RGN_IO);
   assign bank    = addr_hi[0];
   assign is_wr   = !rw;
endmodule

// File: rtl/vpa_slot.sv
module vpa_slot #(
   parameter int POS_W        = 5,
   parameter int CHUNK_W      = 6,
   parameter int SLOT_TICKS   = 24,
   parameter int VID_TICKS    = 16,
   parameter int ACC_TICKS    = 8,
   parameter int NUM_CHUNKS   = 40,
   parameter int FETCH_CHUNKS = 32,
   parameter int CAS_FIRST    = 3,
   parameter int CAS_PERIOD   = 3,
   parameter int BURST        = 4
) (
   input  logic [POS_W-1:0]   slot_pos,
   input  logic [CHUNK_W-1:0] chunk_idx,
   input  logic               line_active,
   output logic               vid_grant,
   output logic               vid_ras,
   output logic               vid_cas,
   output logic               may_start
);
   localparam int CAS_LAST = CAS_FIRST + CAS_PERIOD * BURST - 2;

   always_comb begin
      int  p, c, rel;
      logic fetch, next_fetch, in_burst;
      p          = int'(slot_pos);
      c          = int'(chunk_idx);
      rel        = p - CAS_FIRST;
      fetch      = c < FETCH_CHUNKS;
      next_fetch = (c == NUM_CHUNKS - 1) || (c < FETCH_CHUNKS - 1);
      in_burst   = (p >= CAS_FIRST) && (p <= CAS_LAST) &&
                   ((rel % CAS_PERIOD) != CAS_PERIOD - 1);
      vid_grant  = fetch && (p < VID_TICKS);
      vid_ras    = fetch && (p >= 1) && (p <= VID_TICKS - 2);
      vid_cas    = vid_grant && line_active && in_burst;
      if (slot_pos[0])     may_start = 1'b0;
      else if (fetch)      may_start = (p == VID_TICKS);
      else if (next_fetch) may_start = (p <= SLOT_TICKS - ACC_TICKS);
      else                 may_start = 1'b1;
   end
endmodule

// File: rtl/vpa_seq.sv
module vpa_seq #(
   parameter int ACC_TICKS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ds_n,
   input  logic mem_req,
   input  logic may_start,
   input  logic is_io,
   input  logic bank,
   input  logic is_wr,
   input  logic dram_a3,
   output logic cpu_ras,
   output logic col_phase,
   output logic cpu_cas,
   output logic cas_bank,
   output logic cpu_we,
   output logic pcen,
   output logic ctrl_wr,
   output logic ack
);
   localparam int K_W    = $clog2(ACC_TICKS);
   localparam logic [K_W-1:0] K_RAS  = K_W'(1);
   localparam logic [K_W-1:0] K_COL  = K_W'(2);
   localparam logic [K_W-1:0] K_CAS  = K_W'(3);
   localparam logic [K_W-1:0] K_LAST = K_W'(ACC_TICKS - 1);

   logic           busy_q, io_q, bank_q, wr_q, a6_q, ack_q, served_q;
   logic [K_W-1:0] k_q;
   logic           start;

   assign start = mem_req && may_start && !busy_q && !served_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         k_q      <= '0;
         io_q     <= 1'b0;
         bank_q   <= 1'b0;
         wr_q     <= 1'b0;
         a6_q     <= 1'b0;
         ack_q    <= 1'b0;
         served_q <= 1'b0;
      end else begin
         if (ds_n) begin
            served_q <= 1'b0;
            ack_q    <= 1'b0;
         end
         if (start) begin
            busy_q   <= 1'b1;
            k_q      <= K_RAS;
            io_q     <= is_io;
            bank_q   <= bank;
            wr_q     <= is_wr;
            served_q <= 1'b1;
         end else if (busy_q) begin
            if (k_q == K_COL) begin
               a6_q <= dram_a3;
               if (!ds_n) ack_q <= 1'b1;
            end
            if (k_q == K_LAST) begin
               busy_q <= 1'b0;
               k_q    <= '0;
            end else begin
               k_q <= k_q + K_W'(1);
            end
         end
      end
   end

   logic cas_win;
   assign cas_win   = busy_q && (k_q >= K_CAS) && (k_q < K_LAST);
   assign cpu_ras   = busy_q && (k_q >= K_RAS) && (k_q < K_LAST);
   assign col_phase = busy_q && (k_q >= K_COL);
   assign cpu_cas   = cas_win && !io_q;
   assign cas_bank  = bank_q;
   assign cpu_we    = busy_q && wr_q && (k_q >= K_COL) && (k_q < K_LAST);
   assign pcen      = cas_win && io_q && !a6_q;
   assign ctrl_wr   = busy_q && io_q && a6_q && wr_q && (k_q == K_CAS);
   assign ack       = ack_q;
endmodule

// File: rtl/vpa_dram_ctrl.sv
module vpa_dram_ctrl #(
   parameter int POS_W        = 5,
   parameter int CHUNK_W      = 6,
   parameter int SLOT_TICKS   = vpa_pkg::TICKS_PER_CHUNK,
   parameter int VID_TICKS    = vpa_pkg::VIDEO_TICKS,
   parameter int ACC_TICKS    = vpa_pkg::ACCESS_TICKS,
   parameter int NUM_CHUNKS   = 40,
   parameter int FETCH_CHUNKS = 32,
   parameter int NUM_BANKS    = 2,
   parameter int VID_BANK     = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [POS_W-1:0]     slot_pos,
   input  logic [CHUNK_W-1:0]   chunk_idx,
   input  logic                 line_active,
   input  logic                 ds_n,
   input  logic                 rw,
   input  logic [1:0]           addr_hi,
   input  logic                 dram_a3,
   output logic                 rom_oe,
   output logic                 vid_grant,
   output logic                 ras_n,
   output logic [NUM_BANKS-1:0] cas_n,
   output logic                 we_n,
   output logic                 mux_col,
   output logic                 xcvr_en_n,
   output logic                 dtack_n,
   output logic                 pcen_n,
   output logic                 ctrl_wr
);
   if (VID_TICKS + ACC_TICKS != SLOT_TICKS) begin : g_bad_slot
      $error("video and CPU slots must fill the chunk");
   end
   if (SLOT_TICKS > (1 << POS_W) || NUM_CHUNKS > (1 << CHUNK_W)) begin : g_bad_w
      $error("position or chunk width too small");
   end
   if (NUM_BANKS != 2 || ACC_TICKS < 6 || FETCH_CHUNKS >= NUM_CHUNKS) begin : g_bad_cfg
      $error("unsupported bank count, access length or fetch span");
   end

   logic mem_req, is_io, bank, is_wr;
   logic vid_ras, vid_cas, may_start;
   logic cpu_ras, cpu_cas, cas_bank, cpu_we, pcen, ack;

   vpa_decode u_dec (
      .ds_n(ds_n), .rw(rw), .addr_hi(addr_hi), .rom_oe(rom_oe),
      .mem_req(mem_req), .is_io(is_io), .bank(bank), .is_wr(is_wr)
   );

   vpa_slot #(
      .POS_W(POS_W), .CHUNK_W(CHUNK_W), .SLOT_TICKS(SLOT_TICKS),
      .VID_TICKS(VID_TICKS), .ACC_TICKS(ACC_TICKS),
      .NUM_CHUNKS(NUM_CHUNKS), .FETCH_CHUNKS(FETCH_CHUNKS)
   ) u_slot (
      .slot_pos(slot_pos), .chunk_idx(chunk_idx), .line_active(line_active),
      .vid_grant(vid_grant), .vid_ras(vid_ras), .vid_cas(vid_cas),
      .may_start(may_start)
   );

   vpa_seq #(.ACC_TICKS(ACC_TICKS)) u_seq (
      .clk(clk), .rst_n(rst_n), .ds_n(ds_n), .mem_req(mem_req),
      .may_start(may_start), .is_io(is_io), .bank(bank), .is_wr(is_wr),
      .dram_a3(dram_a3), .cpu_ras(cpu_ras), .col_phase(mux_col),
      .cpu_cas(cpu_cas), .cas_bank(cas_bank), .cpu_we(cpu_we),
      .pcen(pcen), .ctrl_wr(ctrl_wr), .ack(ack)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cas
      logic cpu_hit;
      assign cpu_hit = cpu_cas && (cas_bank == b[0]);
      if (b == VID_BANK) begin : g_vid
         assign cas_n[b] = !(cpu_hit || vid_cas);
      end else begin : g_cpu
         assign cas_n[b] = !cpu_hit;
      end
   end

   assign ras_n     = !(vid_ras || cpu_ras);
   assign we_n      = !cpu_we;
   assign pcen_n    = !pcen;
   assign xcvr_en_n = vid_grant || ras_n;
   assign dtack_n   = !(rom_oe || ack);
endmodule

// File: rtl/vpa_checker.sv
module vpa_checker #(
   parameter int NUM_BANKS = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 ds_n,
   input logic                 rom_oe,
   input logic                 vid_grant,
   input logic                 ras_n,
   input logic [NUM_BANKS-1:0] cas_n,
   input logic                 we_n,
   input logic                 mux_col,
   input logic                 xcvr_en_n,
   input logic                 dtack_n,
   input logic                 pcen_n,
   input logic                 ctrl_wr
);
   a_r1_one_cas: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~cas_n) <= 1);
   a_r2_rom_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
      rom_oe |-> !dtack_n);
   a_r4_vid_no_we: assert property (@(posedge clk) disable iff (!rst_n)
      vid_grant |-> we_n);
   a_r7_cas_in_col: assert property (@(posedge clk) disable iff (!rst_n)
      (!vid_grant && !(&cas_n)) |-> (mux_col && !ras_n));
   a_r8_we_in_col: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> (mux_col && !vid_grant));
   a_r9_pcen_no_cas: assert property (@(posedge clk) disable iff (!rst_n)
      !pcen_n |-> (mux_col && (&cas_n)));
   a_r9_ctrl_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> !ctrl_wr);
   a_r10_xcvr_off_vid: assert property (@(posedge clk) disable iff (!rst_n)
      vid_grant |-> xcvr_en_n);
   a_r11_ack_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!dtack_n && !rom_oe && !ds_n) |=> (!dtack_n || ds_n));
endmodule

bind vpa_dram_ctrl vpa_checker #(.NUM_BANKS(NUM_BANKS)) u_chk (.*);

// File: tb/tb_vpa_dram_ctrl.sv
`timescale 1ns/1ps
module tb_vpa_dram_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] slot_pos = '0;
   logic [5:0] chunk_idx = '0;
   logic       line_active = 1'b1;
   logic       ds_n = 1'b1, rw = 1'b1, dram_a3 = 1'b0;
   logic [1:0] addr_hi = '0;
   logic       rom_oe, vid_grant, ras_n, we_n, mux_col, xcvr_en_n, dtack_n, pcen_n, ctrl_wr;
   logic [1:0] cas_n;

   always #2.5 clk = ~clk;

   vpa_dram_ctrl dut (.*);

   int n_chk = 0, n_fail = 0, cyc = 0;
   int cur_pos = 0, cur_chunk = 0, cur_line = 0;
   logic ds_b = 1'b1, rw_b = 1'b1, a6_b = 1'b0;
   logic [1:0] hi_b = 2'b00;
   // reference model state
   bit m_busy, m_io, m_wr, m_a6, m_ack, m_served, m_bank;
   int m_k;
   int g_chunk, g_pos; bit g_seen;

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   task automatic chk(string tag, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d (chunk %0d tick %0d)",
                  tag, what, act, exp, cur_chunk, cur_pos);
      end
   endtask

   task automatic step();
      bit fetch, nfetch, vg, vras, vcas, legal, req, start, rom, la;
      bit e_ras, e_col, e_cas0, e_cas1, e_we, e_pcen, e_ctl, e_dtack;
      cyc++;
      if (cyc > 150000) begin
         chk("R11", "watchdog", 1, 0);
         finish_run();
      end
      @(negedge clk);
      la          = (cur_line % 4) != 3;
      slot_pos    = 5'(cur_pos);
      chunk_idx   = 6'(cur_chunk);
      line_active = la;
      ds_n = ds_b; rw = rw_b; addr_hi = hi_b;
      dram_a3 = mux_col ? a6_b : !a6_b;
      #1;
      fetch  = cur_chunk < 32;
      nfetch = (cur_chunk == 39) || (cur_chunk < 31);
      vg     = fetch && cur_pos < 16;
      vras   = fetch && cur_pos >= 1 && cur_pos <= 14;
      vcas   = vg && la && (cur_pos inside {3,4,6,7,9,10,12,13});
      legal  = (cur_pos % 2 == 0) && (fetch ? cur_pos == 16 : (nfetch ? cur_pos <= 16 : 1'b1));
      req    = !ds_b && hi_b != 2'b00;
      start  = req && !m_busy && !m_served && legal;
      rom    = !ds_b && rw_b && hi_b == 2'b00;
      e_ras  = !(vras || (m_busy && m_k >= 1 && m_k <= 6));
      e_col  = m_busy && m_k >= 2;
      e_cas0 = !(vcas || (m_busy && !m_io && !m_bank && m_k >= 3 && m_k <= 6));
      e_cas1 = !(m_busy && !m_io && m_bank && m_k >= 3 && m_k <= 6);
      e_we   = !(m_busy && m_wr && m_k >= 2 && m_k <= 6);
      e_pcen = !(m_busy && m_io && !m_a6 && m_k >= 3 && m_k <= 6);
      e_ctl  = m_busy && m_io && m_a6 && m_wr && m_k == 3;
      e_dtack = !(rom || m_ack);
      chk("R2", "rom_oe", rom_oe, rom);
      chk("R3", "vid_grant", vid_grant, vg);
      chk("R7", "ras_n", ras_n, e_ras);
      chk("R7", "mux_col", mux_col, e_col);
      chk("R4", "cas_n[0]", cas_n[0], e_cas0);
      chk("R1", "cas_n[1]", cas_n[1], e_cas1);
      chk("R8", "we_n", we_n, e_we);
      chk("R9", "pcen_n", pcen_n, e_pcen);
      chk("R9", "ctrl_wr", ctrl_wr, e_ctl);
      chk("R10", "xcvr_en_n", xcvr_en_n, !(!vg && !e_ras));
      chk("R11", "dtack_n", dtack_n, e_dtack);
      if (!g_seen && !vid_grant && !ras_n) begin
         g_seen = 1; g_chunk = cur_chunk; g_pos = cur_pos;
      end
      // model update, mirrors the coming clock edge
      if (ds_b) begin m_served = 0; m_ack = 0; end
      if (start) begin
         m_busy = 1; m_k = 1; m_io = (hi_b == 2'b01); m_bank = hi_b[0];
         m_wr = !rw_b; m_served = 1;
      end else if (m_busy) begin
         if (m_k == 2) begin m_a6 = dram_a3; if (!ds_b) m_ack = 1; end
         if (m_k == 7) begin m_busy = 0; m_k = 0; end else m_k++;
      end
      cur_pos++;
      if (cur_pos == 24) begin
         cur_pos = 0; cur_chunk++;
         if (cur_chunk == 40) begin cur_chunk = 0; cur_line++; end
      end
   endtask

   task automatic goto_pos(int c, int p, int blank);
      while (!(cur_chunk == c && cur_pos == p &&
               (blank < 0 || (((cur_line % 4) == 3) == (blank == 1)))))
         step();
   endtask

   // exp_c < 0 marks a ROM access (no DRAM cycle expected)
   task automatic xfer(string tag, int c, int p, int blank, logic [1:0] hi,
                       logic rdwr, logic a6, int exp_c, int exp_p);
      int n = 0; bit got = 0;
      goto_pos(c, p, blank);
      hi_b = hi; rw_b = rdwr; a6_b = a6; ds_b = 1'b0; g_seen = 0;
      while (!got && n < 200) begin
         step(); n++;
         if (dtack_n == 1'b0) got = 1;
      end
      chk(tag, "acknowledge seen", got, 1);
      if (exp_c < 0) chk(tag, "rom wait ticks", n, 1);
      else begin
         chk(tag, "first RAS tick chunk", g_chunk, exp_c);
         chk(tag, "first RAS tick pos", g_pos, exp_p);
      end
      repeat (12) step();          // strobe held: no second access (R11)
      ds_b = 1'b1; rw_b = 1'b1; hi_b = 2'b00;
      repeat (3) step();
   endtask

   initial begin
      chunk_idx = 6'd35;
      repeat (3) @(negedge clk);
      #1;
      chk("R11", "reset dtack_n", dtack_n, 1);
      chk("R11", "reset ras_n", ras_n, 1);
      chk("R11", "reset cas_n", cas_n, 2'b11);
      chk("R11", "reset mux_col", mux_col, 0);
      chk("R9", "reset ctrl_wr", ctrl_wr, 0);
      rst_n = 1'b1;
      // R2: ROM read inside the video slot is served at once
      xfer("R2", 2, 3, -1, 2'b00, 1'b1, 1'b0, -1, 0);
      // R5: early request in a fetch chunk waits for tick 16
      xfer("R5", 5, 2, 0, 2'b10, 1'b1, 1'b0, 5, 17);
      // R5/R4: same on a blank (refresh) line
      xfer("R5", 10, 0, 1, 2'b10, 1'b1, 1'b0, 10, 17);
      // R6/R1/R8: odd retrace tick, bank 1 write moves to next even tick
      xfer("R6", 34, 5, -1, 2'b11, 1'b0, 1'b0, 34, 7);
      // R6: access that crosses into the next retrace chunk
      xfer("R6", 38, 20, -1, 2'b10, 1'b0, 1'b0, 38, 21);
      // R9: I/O write with bit 6 set hits the control register
      xfer("R9", 36, 10, -1, 2'b01, 1'b0, 1'b1, 36, 11);
      // R6/R9: too close to the fetch slot, held into the next line
      xfer("R6", 39, 18, -1, 2'b01, 1'b1, 1'b0, 0, 17);
      // R6: last start that still fits in chunk 39
      xfer("R6", 39, 16, -1, 2'b10, 1'b0, 1'b0, 39, 17);
      // R5/R9: fetch chunk 31 holds to retrace chunk 32 tick 0; I/O write, bit 6 clear
      xfer("R5", 31, 18, -1, 2'b01, 1'b0, 1'b0, 32, 1);
      // R9: I/O read with bit 6 set: neither enable nor write strobe
      xfer("R9", 33, 2, -1, 2'b01, 1'b1, 1'b1, 33, 3);
      // R3/R4: idle span across pixel and blank lines
      repeat (2000) step();
      finish_run();
   end
endmodule